// File: doc/BRIEF.md
# Return Address Stack Unit

This block keeps the 13-bit program counter of a small 8-bit accumulator machine together with a push-down stack of return addresses. Each cycle it takes at most one control-transfer request (jump, call or return) or a plain sequential advance. It then produces the next program counter. A transfer can be unconditional, or it can be gated by one of eight tests of the carry, zero, sign and parity flags.

The branch target arrives as two bytes, low byte first and high byte second. A taken call saves the address of the instruction that follows the three-byte call and then loads the target. A taken return reloads the counter from the most recent saved address. The stack is fifteen levels deep. If it overflows, the oldest entry is lost. If it is popped when empty, the counter is loaded with zero. Each of these events is recorded in a sticky flag that only reset clears. Instruction fetch, decoding and the ALU belong to neighbouring blocks.

Top module: `pcstk_unit`

## Requirements
- R1: After reset, `pc_o` is 0, `taken_o`, `stk_ovf_o` and `stk_udf_o` are 0, and the stack is empty.
- R2: A taken jump loads `pc_o` on the next clock edge with the target `{addr_hi_i[4:0], addr_lo_i}`. Bits 7..5 of `addr_hi_i` have no effect.
- R3: A taken call pushes `(pc_o + 3) mod 8192` and loads the target on the same edge. Nested calls are saved in last-in, first-out order.
- R4: A taken return loads `pc_o` from the most recently pushed entry and removes that entry.
- R5: With `cond_en_i` = 0 the request is always taken. With `cond_en_i` = 1, `cond_sel_i[1:0]` selects the flag (00 carry, 01 zero, 10 sign, 11 parity) and `cond_sel_i[2]` gives the value that flag must have for the branch to be taken. Codes 000 to 011 therefore mean carry clear, zero clear, sign clear and parity odd. Codes 100 to 111 mean carry set, zero set, sign set and parity even. `flag_par_i` = 1 means even parity.
- R6: A jump or call whose condition fails advances `pc_o` by 3. A return whose condition fails advances it by 1. In both cases the stack is left unchanged.
- R7: `taken_o` is 1 in the cycle after a request whose branch was taken, and 0 otherwise, including after sequential advances.
- R8: A push onto a stack that already holds 15 entries drops the oldest entry and sets `stk_ovf_o`, which stays 1 until reset.
- R9: A taken return on an empty stack loads `pc_o` with 0 and sets `stk_udf_o`, which stays 1 until reset.
- R10: `op_seq_i` advances `pc_o` by `seq_len_i` (0 to 3) modulo 8192.
- R11: When several strobes are high together, only the highest-priority one acts. The order is call, then jump, then return, then sequential advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_seq_i | input | 1 | Sequential advance request |
| seq_len_i | input | 2 | Byte count for a sequential advance |
| op_jump_i | input | 1 | Jump request |
| op_call_i | input | 1 | Call request |
| op_ret_i | input | 1 | Return request |
| cond_en_i | input | 1 | 1 = conditional form, 0 = unconditional |
| cond_sel_i | input | 3 | Condition code |
| flag_cy_i | input | 1 | Carry flag |
| flag_zr_i | input | 1 | Zero flag |
| flag_sg_i | input | 1 | Sign flag |
| flag_par_i | input | 1 | Parity flag, 1 = even |
| addr_lo_i | input | 8 | Target address, low byte |
| addr_hi_i | input | 8 | Target address, high byte (bits 4..0 used) |
| pc_o | output | 13 | Program counter |
| taken_o | output | 1 | Last request was a taken branch |
| stk_ovf_o | output | 1 | Sticky stack overflow |
| stk_udf_o | output | 1 | Sticky stack underflow |

## Verification
The bench runs all eight condition codes against all sixteen flag combinations. A design that swapped the set and clear senses, or mapped parity the wrong way, would take exactly the branches it should skip. Calls near the top of the address space check that the saved return address wraps to 13 bits. If it did not wrap, the matching return would land at a wrong address. The bench fills the stack past fifteen levels and then drains it past empty. A design with a misplaced discard or a missing zero fill would return stale addresses or miss the sticky flags. Cycles with several strobes high at once expose a priority order that differs from the required one.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

   typedef enum logic [2:0] {
      XFER_NONE,
      XFER_SEQ,
      XFER_JUMP,
      XFER_CALL,
      XFER_RET
   } xfer_kind_e;

   typedef enum logic [1:0] {
      FSEL_CARRY  = 2'b00,
      FSEL_ZERO   = 2'b01,
      FSEL_SIGN   = 2'b10,
      FSEL_PARITY = 2'b11
   } flag_sel_e;

   function automatic xfer_kind_e pick_kind(input logic call_r, input logic jump_r,
                                            input logic ret_r, input logic seq_r);
      xfer_kind_e k;
      if (call_r)      k = XFER_CALL;
      else if (jump_r) k = XFER_JUMP;
      else if (ret_r)  k = XFER_RET;
      else if (seq_r)  k = XFER_SEQ;
      else             k = XFER_NONE;
      return k;
   endfunction

endpackage

// File: rtl/pcstk_cond.sv
module pcstk_cond
   import pcstk_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             cond_en_i,
   input  logic [SEL_W-1:0] cond_sel_i,
   input  logic             flag_cy_i,
   input  logic             flag_zr_i,
   input  logic             flag_sg_i,
   input  logic             flag_par_i,
   output logic             pass_o
);
   localparam int POL_BIT = SEL_W - 1;

   generate
      if (SEL_W != 3) begin : g_bad_sel
         $error("pcstk_cond: SEL_W must be 3");
      end
   endgenerate

   flag_sel_e fsel;
   logic      picked;

   always_comb begin
      fsel = flag_sel_e'(cond_sel_i[1:0]);
      unique case (fsel)
         FSEL_CARRY:  picked = flag_cy_i;
         FSEL_ZERO:   picked = flag_zr_i;
         FSEL_SIGN:   picked = flag_sg_i;
         FSEL_PARITY: picked = flag_par_i;
         default:     picked = 1'b0;
      endcase
      pass_o = !cond_en_i || (picked == cond_sel_i[POL_BIT]);
   end

endmodule

// File: rtl/pcstk_lifo.sv
module pcstk_lifo #(
   parameter int W     = 13,
   parameter int DEPTH = 15
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_data_i,
   output logic [W-1:0] top_o,
   output logic         ovf_o,
   output logic         udf_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pcstk_lifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("pcstk_lifo: W must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             full, empty;

   assign full  = (cnt_q == CNT_FULL);
   assign empty = (cnt_q == '0);

   // Push-down chain: stage 0 is the top; a push shifts toward the bottom,
   // a pop shifts toward the top and fills the bottom with zero.
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         logic [W-1:0] q;
         logic [W-1:0] from_above;
         logic [W-1:0] from_below;

         if (i == 0) begin : g_first
            assign from_above = push_data_i;
         end else begin : g_mid_a
            assign from_above = g_stage[i-1].q;
         end

         if (i == DEPTH - 1) begin : g_last
            assign from_below = '0;
         end else begin : g_mid_b
            assign from_below = g_stage[i+1].q;
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     q <= '0;
            else if (push_i) q <= from_above;
            else if (pop_i)  q <= from_below;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ovf_o <= 1'b0;
         udf_o <= 1'b0;
      end else if (push_i) begin
         if (full) ovf_o <= 1'b1;
         else      cnt_q <= cnt_q + 1'b1;
      end else if (pop_i) begin
         if (empty) udf_o <= 1'b1;
         else       cnt_q <= cnt_q - 1'b1;
      end
   end

   assign top_o = empty ? '0 : g_stage[0].q;

endmodule

// File: rtl/pcstk_next.sv
module pcstk_next
   import pcstk_pkg::*;
#(
   parameter int PC_W     = 13,
   parameter int CALL_LEN = 3,
   parameter int JUMP_LEN = 3,
   parameter int RET_LEN  = 1,
   parameter int LEN_W    = 2
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic             op_seq_i,
   input  logic [LEN_W-1:0] seq_len_i,
   input  logic             op_jump_i,
   input  logic             op_call_i,
   input  logic             op_ret_i,
   input  logic             pass_i,
   input  logic [PC_W-1:0]  target_i,
   input  logic [PC_W-1:0]  top_i,
   output logic [PC_W-1:0]  pc_nxt_o,
   output logic             push_o,
   output logic             pop_o,
   output logic [PC_W-1:0]  push_data_o,
   output logic             taken_nxt_o
);
   localparam logic [PC_W-1:0] CALL_STEP = PC_W'(CALL_LEN);
   localparam logic [PC_W-1:0] JUMP_STEP = PC_W'(JUMP_LEN);
   localparam logic [PC_W-1:0] RET_STEP  = PC_W'(RET_LEN);

   xfer_kind_e kind;

   always_comb begin
      kind        = pick_kind(op_call_i, op_jump_i, op_ret_i, op_seq_i);
      pc_nxt_o    = pc_i;
      push_o      = 1'b0;
      pop_o       = 1'b0;
      taken_nxt_o = 1'b0;
      push_data_o = pc_i + CALL_STEP;
      unique case (kind)
         XFER_CALL: begin
            if (pass_i) begin
               push_o      = 1'b1;
               pc_nxt_o    = target_i;
               taken_nxt_o = 1'b1;
            end else begin
               pc_nxt_o = pc_i + CALL_STEP;
            end
         end
         XFER_JUMP: begin
            if (pass_i) begin
               pc_nxt_o    = target_i;
               taken_nxt_o = 1'b1;
            end else begin
               pc_nxt_o = pc_i + JUMP_STEP;
            end
         end
         XFER_RET: begin
            if (pass_i) begin
               pop_o       = 1'b1;
               pc_nxt_o    = top_i;
               taken_nxt_o = 1'b1;
            end else begin
               pc_nxt_o = pc_i + RET_STEP;
            end
         end
         XFER_SEQ: pc_nxt_o = pc_i + PC_W'(seq_len_i);
         default:  pc_nxt_o = pc_i;
      endcase
   end

endmodule

// File: rtl/pcstk_unit.sv
module pcstk_unit #(
   parameter int PC_W     = 13,
   parameter int BYTE_W   = 8,
   parameter int DEPTH    = 15,
   parameter int SEL_W    = 3,
   parameter int LEN_W    = 2,
   parameter int CALL_LEN = 3,
   parameter int JUMP_LEN = 3,
   parameter int RET_LEN  = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              op_seq_i,
   input  logic [LEN_W-1:0]  seq_len_i,
   input  logic              op_jump_i,
   input  logic              op_call_i,
   input  logic              op_ret_i,
   input  logic              cond_en_i,
   input  logic [SEL_W-1:0]  cond_sel_i,
   input  logic              flag_cy_i,
   input  logic              flag_zr_i,
   input  logic              flag_sg_i,
   input  logic              flag_par_i,
   input  logic [BYTE_W-1:0] addr_lo_i,
   input  logic [BYTE_W-1:0] addr_hi_i,
   output logic [PC_W-1:0]   pc_o,
   output logic              taken_o,
   output logic              stk_ovf_o,
   output logic              stk_udf_o
);
   localparam int HI_USED = PC_W - BYTE_W;
   localparam int HI_DROP = BYTE_W - HI_USED;

   generate
      if (PC_W <= BYTE_W || PC_W > 2 * BYTE_W) begin : g_bad_pc
         $error("pcstk_unit: PC_W must lie between BYTE_W+1 and 2*BYTE_W");
      end
      if (CALL_LEN < 1 || JUMP_LEN < 1 || RET_LEN < 1) begin : g_bad_len
         $error("pcstk_unit: instruction lengths must be positive");
      end
   endgenerate

   // Target assembly: low byte, then the used bits of the high byte.
   logic [PC_W-1:0] target;
   assign target = {addr_hi_i[HI_USED-1:0], addr_lo_i};

   logic unused_hi_bits;
   generate
      if (HI_DROP > 0) begin : g_drop
         assign unused_hi_bits = &{1'b0, addr_hi_i[BYTE_W-1:HI_USED]};
      end else begin : g_nodrop
         assign unused_hi_bits = 1'b0;
      end
   endgenerate

   logic            pass;
   logic            push, pop, taken_nxt;
   logic [PC_W-1:0] pc_nxt, push_data, top;

   pcstk_cond #(.SEL_W(SEL_W)) u_cond (
      .cond_en_i  (cond_en_i),
      .cond_sel_i (cond_sel_i),
      .flag_cy_i  (flag_cy_i),
      .flag_zr_i  (flag_zr_i),
      .flag_sg_i  (flag_sg_i),
      .flag_par_i (flag_par_i),
      .pass_o     (pass)
   );

   pcstk_next #(
      .PC_W(PC_W), .CALL_LEN(CALL_LEN), .JUMP_LEN(JUMP_LEN),
      .RET_LEN(RET_LEN), .LEN_W(LEN_W)
   ) u_next (
      .pc_i        (pc_o),
      .op_seq_i    (op_seq_i),
      .seq_len_i   (seq_len_i),
      .op_jump_i   (op_jump_i),
      .op_call_i   (op_call_i),
      .op_ret_i    (op_ret_i),
      .pass_i      (pass),
      .target_i    (target),
      .top_i       (top),
      .pc_nxt_o    (pc_nxt),
      .push_o      (push),
      .pop_o       (pop),
      .push_data_o (push_data),
      .taken_nxt_o (taken_nxt)
   );

   pcstk_lifo #(.W(PC_W), .DEPTH(DEPTH)) u_lifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .pop_i       (pop),
      .push_data_i (push_data),
      .top_o       (top),
      .ovf_o       (stk_ovf_o),
      .udf_o       (stk_udf_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_o    <= '0;
         taken_o <= 1'b0;
      end else begin
         pc_o    <= pc_nxt;
         taken_o <= taken_nxt;
      end
   end

endmodule

// File: rtl/pcstk_unit_chk.sv
module pcstk_unit_chk #(
   parameter int PC_W     = 13,
   parameter int SEL_W    = 3,
   parameter int CALL_LEN = 3,
   parameter int JUMP_LEN = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             op_seq_i,
   input logic             op_jump_i,
   input logic             op_call_i,
   input logic             op_ret_i,
   input logic             cond_en_i,
   input logic [SEL_W-1:0] cond_sel_i,
   input logic             flag_cy_i,
   input logic             flag_zr_i,
   input logic             flag_sg_i,
   input logic             flag_par_i,
   input logic [PC_W-1:0]  tgt_i,
   input logic [PC_W-1:0]  pc_o,
   input logic             taken_o,
   input logic             stk_ovf_o,
   input logic             stk_udf_o
);
   logic flag_pick, cond_ok;
   always_comb begin
      case (cond_sel_i[1:0])
         2'b00:   flag_pick = flag_cy_i;
         2'b01:   flag_pick = flag_zr_i;
         2'b10:   flag_pick = flag_sg_i;
         default: flag_pick = flag_par_i;
      endcase
      cond_ok = !cond_en_i || (flag_pick == cond_sel_i[SEL_W-1]);
   end

   a_r2_uncond_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_jump_i && !op_call_i && !cond_en_i) |=> (pc_o == $past(tgt_i) && taken_o));

   a_r3_uncond_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_call_i && !cond_en_i) |=> (pc_o == $past(tgt_i) && taken_o));

   a_r6_skip_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_jump_i && !op_call_i && !cond_ok)
      |=> (pc_o == PC_W'($past(pc_o) + PC_W'(JUMP_LEN)) && !taken_o));

   a_r6_skip_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_call_i && !cond_ok)
      |=> (pc_o == PC_W'($past(pc_o) + PC_W'(CALL_LEN)) && !taken_o));

   a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!op_call_i && !op_jump_i && !op_ret_i) |=> !taken_o);

   a_r10_seq_untaken: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_seq_i && !op_call_i && !op_jump_i && !op_ret_i) |=> !taken_o);

   a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stk_ovf_o |=> stk_ovf_o);

   a_r9_udf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stk_udf_o |=> stk_udf_o);

endmodule

bind pcstk_unit pcstk_unit_chk #(
   .PC_W(PC_W), .SEL_W(SEL_W), .CALL_LEN(CALL_LEN), .JUMP_LEN(JUMP_LEN)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .op_seq_i   (op_seq_i),
   .op_jump_i  (op_jump_i),
   .op_call_i  (op_call_i),
   .op_ret_i   (op_ret_i),
   .cond_en_i  (cond_en_i),
   .cond_sel_i (cond_sel_i),
   .flag_cy_i  (flag_cy_i),
   .flag_zr_i  (flag_zr_i),
   .flag_sg_i  (flag_sg_i),
   .flag_par_i (flag_par_i),
   .tgt_i      (target),
   .pc_o       (pc_o),
   .taken_o    (taken_o),
   .stk_ovf_o  (stk_ovf_o),
   .stk_udf_o  (stk_udf_o)
);

// File: tb/pcstk_unit_tb_top.sv
module pcstk_unit_tb_top;
   localparam int PC_W  = 13;
   localparam int MASK  = (1 << PC_W) - 1;
   localparam int DEPTH = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       op_seq = 0, op_jump = 0, op_call = 0, op_ret = 0, cond_en = 0;
   logic [1:0] seq_len = 0;
   logic [2:0] cond_sel = 0;
   logic       f_cy = 0, f_zr = 0, f_sg = 0, f_par = 0;
   logic [7:0] a_lo = 0, a_hi = 0;
   logic [PC_W-1:0] pc;
   logic taken, ovf, udf;

   pcstk_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .op_seq_i(op_seq), .seq_len_i(seq_len),
      .op_jump_i(op_jump), .op_call_i(op_call), .op_ret_i(op_ret),
      .cond_en_i(cond_en), .cond_sel_i(cond_sel), .flag_cy_i(f_cy),
      .flag_zr_i(f_zr), .flag_sg_i(f_sg), .flag_par_i(f_par),
      .addr_lo_i(a_lo), .addr_hi_i(a_hi), .pc_o(pc), .taken_o(taken),
      .stk_ovf_o(ovf), .stk_udf_o(udf)
   );

   // Behavioural reference state
   int m_pc = 0;
   bit m_taken = 0, m_ovf = 0, m_udf = 0;
   int m_stack[$];

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic compare(input string tag);
      n_cmp++;
      if (pc !== PC_W'(m_pc) || taken !== m_taken || ovf !== m_ovf || udf !== m_udf) begin
         n_bad++;
         $display("FAIL %s: pc=%h taken=%b ovf=%b udf=%b expected pc=%h taken=%b ovf=%b udf=%b",
                  tag, pc, taken, ovf, udf, PC_W'(m_pc), m_taken, m_ovf, m_udf);
      end
   endtask

   function automatic bit model_pass(input bit cen, input logic [2:0] sel, input logic [3:0] fl);
      bit f;
      if (!cen) return 1;
      case (sel[1:0])
         2'd0: f = fl[3];
         2'd1: f = fl[2];
         2'd2: f = fl[1];
         default: f = fl[0];
      endcase
      return f == sel[2];
   endfunction

   // fl = {carry, zero, sign, parity}
   task automatic op(input bit c, input bit j, input bit r, input bit s, input int len,
                     input bit cen, input logic [2:0] sel, input logic [3:0] fl,
                     input logic [7:0] lo, input logic [7:0] hi, input string tag);
      bit p;
      int tgt;
      op_call = c; op_jump = j; op_ret = r; op_seq = s; seq_len = 2'(len);
      cond_en = cen; cond_sel = sel; {f_cy, f_zr, f_sg, f_par} = fl;
      a_lo = lo; a_hi = hi;
      @(posedge clk);
      p = model_pass(cen, sel, fl);
      tgt = ((int'(hi) & 31) << 8) | int'(lo);
      m_taken = 0;
      if (c) begin
         if (p) begin
            m_stack.push_front((m_pc + 3) & MASK);
            if (m_stack.size() > DEPTH) begin
               void'(m_stack.pop_back());
               m_ovf = 1;
            end
            m_pc = tgt; m_taken = 1;
         end else m_pc = (m_pc + 3) & MASK;
      end else if (j) begin
         if (p) begin m_pc = tgt; m_taken = 1; end
         else m_pc = (m_pc + 3) & MASK;
      end else if (r) begin
         if (p) begin
            if (m_stack.size() == 0) begin m_pc = 0; m_udf = 1; end
            else m_pc = m_stack.pop_front();
            m_taken = 1;
         end else m_pc = (m_pc + 1) & MASK;
      end else if (s) begin
         m_pc = (m_pc + len) & MASK;
      end
      @(negedge clk);
      op_call = 0; op_jump = 0; op_ret = 0; op_seq = 0;
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset");

      // R10 sequential advance and wrap
      op(0,0,0,1, 1, 0,3'd0,4'h0, 8'h00,8'h00, "R10 seq+1");
      op(0,0,0,1, 3, 0,3'd0,4'h0, 8'h00,8'h00, "R10 seq+3");
      op(0,0,0,1, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R10 seq+0");
      // R2 jump, upper high-byte bits ignored
      op(0,1,0,0, 0, 0,3'd0,4'h0, 8'hFF,8'hFF, "R2 jump to top");
      op(0,0,0,1, 2, 0,3'd0,4'h0, 8'h00,8'h00, "R10 wrap");
      op(0,1,0,0, 0, 0,3'd0,4'h0, 8'h34,8'hE7, "R2 hi bits ignored");
      op(0,1,0,0, 0, 0,3'd0,4'h0, 8'h34,8'h07, "R2 hi bits clear");

      // R5/R6 every condition code against every flag combination
      for (int sel = 0; sel < 8; sel++) begin
         for (int fl = 0; fl < 16; fl++) begin
            op(0,1,0,0, 0, 1,3'(sel),4'(fl), 8'(sel*16+fl),8'h02, "R5 R6 cond jump");
         end
      end

      // R3/R4 nested calls and returns
      op(0,1,0,0, 0, 0,3'd0,4'h0, 8'h00,8'h01, "R2 setup");
      op(1,0,0,0, 0, 0,3'd0,4'h0, 8'h00,8'h03, "R3 call 1");
      op(1,0,0,0, 0, 1,3'd5,4'h4, 8'h50,8'h04, "R3 cond call taken");
      op(1,0,0,0, 0, 1,3'd5,4'h0, 8'h60,8'h05, "R6 cond call skipped");
      op(1,0,0,0, 0, 0,3'd0,4'h0, 8'h10,8'h0A, "R3 call 3");
      op(0,0,1,0, 0, 1,3'd7,4'h0, 8'h00,8'h00, "R6 cond ret skipped");
      op(0,0,1,0, 0, 1,3'd3,4'h0, 8'h00,8'h00, "R4 cond ret taken");
      op(0,0,1,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R4 ret 2");
      op(0,0,1,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R4 ret 1");
      // R3 return address wraps
      op(0,1,0,0, 0, 0,3'd0,4'h0, 8'hFE,8'h1F, "R2 near top");
      op(1,0,0,0, 0, 0,3'd0,4'h0, 8'h22,8'h01, "R3 call near top");
      op(0,0,1,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R3 wrapped return");

      // R11 priority
      op(1,1,1,1, 3, 0,3'd0,4'h0, 8'h77,8'h06, "R11 call wins");
      op(0,1,1,1, 3, 0,3'd0,4'h0, 8'h88,8'h08, "R11 jump wins");
      op(0,0,1,1, 3, 0,3'd0,4'h0, 8'h00,8'h00, "R11 ret wins");
      op(0,0,1,1, 3, 1,3'd4,4'h0, 8'h00,8'h00, "R11 R6 ret skipped over seq");
      op(0,0,0,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R7 idle");

      // R8 overflow: 17 pushes on 15 levels
      for (int k = 0; k < DEPTH + 2; k++) begin
         op(1,0,0,0, 0, 0,3'd0,4'h0, 8'(k*8),8'(k), "R8 fill");
      end
      // R9 drain past empty
      for (int k = 0; k < DEPTH + 2; k++) begin
         op(0,0,1,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R8 R9 drain");
      end
      op(0,0,0,1, 1, 0,3'd0,4'h0, 8'h00,8'h00, "R8 R9 sticky");

      // R1 reset clears sticky flags
      rst_n = 1'b0;
      m_pc = 0; m_taken = 0; m_ovf = 0; m_udf = 0; m_stack.delete();
      @(negedge clk);
      compare("R1 re-reset");
      rst_n = 1'b1;
      op(0,0,1,0, 0, 0,3'd0,4'h0, 8'h00,8'h00, "R1 R9 stack empty after reset");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule